// File: doc/BRIEF.md
# Block Write Packetizer

This block turns one block write into a byte stream that a serial host can shift out. A transfer starts with a one-cycle `start` pulse that carries the total byte count, a 3-bit packet-size code and a trailer enable. The block cuts the transfer into packets no longer than the selected maximum. Each packet opens with a marker byte that tells the far end whether the packet is the first of several, a middle one, or the last (or only) one. The payload bytes follow, and two zero trailer bytes may close the packet.

Payload bytes pass straight from a ready/valid byte input to a ready/valid byte output. An input byte is consumed only in the cycle the output accepts it. A one-byte request is widened to two bytes, so the block pulls two bytes from the input. A zero-byte request is rejected with an error pulse and sends nothing. A one-cycle `done` pulse marks the end of a transfer.

Top module: `spi_blkwr_pkt`

## Requirements
- R1: After reset the block is idle: `out_valid`, `in_ready`, `busy`, `done` and `size_err` are all low.
- R2: Each packet starts with the marker byte 0xF0 | order. Order is 3 when the remaining byte count is no larger than the maximum packet size, 1 for the first packet of a longer transfer, and 2 otherwise.
- R3: The payload length of a packet is the smaller of the remaining count and the maximum packet size. Payload bytes appear on the output in input order. During payload, `in_ready` equals `out_ready` and `out_valid` equals `in_valid`.
- R4: With `crc_en` set at start, every payload is followed by the two bytes 0x00, 0x00. With `crc_en` clear there is no trailer.
- R5: The maximum packet size is 2^(MIN_LOG2 + c), where c is `pkt_code` for codes 0 to 5, and codes 6 and 7 act as code 5. With the default MIN_LOG2 = 8 this gives 256 to 8192 bytes.
- R6: A requested size of 1 is handled as 2: one packet with marker 0xF3 and two payload bytes taken from the input.
- R7: A requested size of 0 raises `size_err` for exactly one cycle, the cycle after `start`. It produces no output byte and leaves the block idle.
- R8: `done` is high for exactly one cycle, the cycle after the final byte of the transfer (trailer included) is accepted. It is low at all other times.
- R9: `xfer_size`, `pkt_code` and `crc_en` are captured at `start`. A `start` pulse or a change to these inputs while `busy` is high has no effect on the stream in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| xfer_size | input | SIZE_W | Total transfer size in bytes |
| pkt_code | input | 3 | Maximum packet size code |
| crc_en | input | 1 | Append a two-byte trailer to each packet |
| in_data | input | 8 | Payload byte input |
| in_valid | input | 1 | Payload byte is available |
| in_ready | output | 1 | Payload byte is consumed this cycle |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Receiver accepts the output byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| size_err | output | 1 | One-cycle pulse for a zero-size request |

## Verification
The bench builds the block with MIN_LOG2 = 2, so packet sizes run from 4 to 128 bytes. Short transfers therefore already cross several packet boundaries. Every size from 1 to 20 is swept against all eight size codes, with the trailer on and off and with both steady and irregular handshakes; this reaches the first, middle and last marker codes as well as the widening of single-byte requests. Longer 300-byte transfers for every code exercise long chains of middle packets and the clamping of codes 6 and 7. Dedicated runs cover zero-size rejection and a second start issued in the middle of a transfer.

// File: rtl/spi_blkwr_pkt.sv
module spi_blkwr_pkt #(
  parameter int SIZE_W   = 17,
  parameter int MIN_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] xfer_size,
  input  logic [2:0]        pkt_code,
  input  logic              crc_en,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              busy,
  output logic              done,
  output logic              size_err
);

  localparam int CW = SIZE_W + MIN_LOG2 + 6;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PAY, S_TR0, S_TR1} st_t;

  st_t               st;
  logic [SIZE_W-1:0] rem, cnt;
  logic              first, crc_q, done_q, err_q;
  logic [2:0]        code_q;

  logic [2:0]    eff_code;
  logic [CW-1:0] maxpkt;
  logic          fits, fire;
  logic [1:0]    order;

  assign eff_code = (code_q > 3'd5) ? 3'd5 : code_q;
  assign maxpkt   = CW'(1) << (MIN_LOG2 + int'(eff_code));
  assign fits     = CW'(rem) <= maxpkt;
  assign order    = fits ? 2'd3 : (first ? 2'd1 : 2'd2);

  assign out_valid = (st == S_HDR) || (st == S_TR0) || (st == S_TR1) ||
                     ((st == S_PAY) && in_valid);
  assign out_data  = (st == S_HDR) ? {6'b111100, order} :
                     (st == S_PAY) ? in_data : 8'h00;
  assign in_ready  = (st == S_PAY) && out_ready;
  assign fire      = out_valid && out_ready;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign size_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      cnt    <= '0;
      first  <= 1'b0;
      crc_q  <= 1'b0;
      code_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (xfer_size == '0) begin
            err_q <= 1'b1;
          end else begin
            rem    <= (xfer_size == SIZE_W'(1)) ? SIZE_W'(2) : xfer_size;
            first  <= 1'b1;
            crc_q  <= crc_en;
            code_q <= pkt_code;
            st     <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          cnt <= fits ? rem : maxpkt[SIZE_W-1:0];
          st  <= S_PAY;
        end
        S_PAY: if (fire) begin
          rem <= rem - SIZE_W'(1);
          cnt <= cnt - SIZE_W'(1);
          if (cnt == SIZE_W'(1)) begin
            first <= 1'b0;
            if (crc_q) begin
              st <= S_TR0;
            end else if (rem == SIZE_W'(1)) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              st <= S_HDR;
            end
          end
        end
        S_TR0: if (fire) st <= S_TR1;
        S_TR1: if (fire) begin
          if (rem == '0) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= S_HDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_blkwr_pkt_chk.sv
module spi_blkwr_pkt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       in_valid,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done,
  input logic       size_err
);

  // R3
  pay_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && busy && (out_valid == in_valid)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !busy && !out_valid && !done);

  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |=> !size_err);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !in_ready);

  // R2
  framing_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_ready && !(in_valid && busy && out_ready && out_data[7:4] != 4'hF && out_data != 8'h00))
      |-> (out_data[7:4] == 4'hF || out_data == 8'h00 || in_valid));

endmodule

bind spi_blkwr_pkt spi_blkwr_pkt_chk u_chk (.*);

// File: tb/tb_spi_blkwr_pkt.sv
module tb_spi_blkwr_pkt;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 17;
  localparam int ML = 2;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [SW-1:0] xfer_size = '0;
  logic [2:0]    pkt_code = '0;
  logic          crc_en = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid, busy, done, size_err;
  logic [7:0]    out_data;

  int total = 0, bad = 0;
  logic [7:0] exp_b [0:1023];
  int         exp_k [0:1023];
  int         exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_blkwr_pkt #(.SIZE_W(SW), .MIN_LOG2(ML)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
    .pkt_code(pkt_code), .crc_en(crc_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
    .done(done), .size_err(size_err));

  function automatic logic [7:0] pat(int j, int sz);
    return 8'((j * 37 + sz * 11 + 5) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build(int sz, int code, bit crc);
    int rem, mp, len, p;
    bit first;
    rem = (sz == 1) ? 2 : sz;
    mp = 1 << (ML + ((code > 5) ? 5 : code));
    first = 1; p = 0; exp_n = 0;
    while (rem > 0) begin
      len = (rem < mp) ? rem : mp;
      exp_b[exp_n] = 8'hF0 | ((rem <= mp) ? 8'd3 : (first ? 8'd1 : 8'd2));
      exp_k[exp_n] = 0; exp_n++;
      for (int q = 0; q < len; q++) begin
        exp_b[exp_n] = pat(p, sz); exp_k[exp_n] = 1; exp_n++; p++;
      end
      if (crc) begin
        for (int q = 0; q < 2; q++) begin
          exp_b[exp_n] = 8'h00; exp_k[exp_n] = 2; exp_n++;
        end
      end
      rem -= len; first = 0;
    end
  endtask

  task automatic run(int sz, int code, bit crc, int stall, bit poke, string tag);
    int i, din, cyc;
    bit pend, fin;
    string req;
    build(sz, code, crc);
    @(negedge clk);
    xfer_size = SW'(sz); pkt_code = 3'(code); crc_en = crc; start = 1'b1;
    i = 0; din = 0; cyc = 0; pend = 0; fin = 0;
    while (!fin && cyc < 5000) begin
      @(negedge clk);
      start = poke && (cyc == 4);
      if (poke && cyc == 4) begin
        xfer_size = SW'(5); pkt_code = 3'd7; crc_en = !crc;
      end
      out_ready = (stall == 0) ? 1'b1 : (((cyc * 5 + 3) % 7) != 0);
      in_valid  = (stall == 0) ? 1'b1 : (((cyc * 3 + 1) % 5) != 0);
      in_data   = pat(din, sz);
      #1;
      if (pend) begin
        check(done == 1'b1, "R8 done after final byte", done, 1);
        fin = 1;
      end else if (done) begin
        check(1'b0, "R8 early done", done, 0);
      end
      if (out_valid && out_ready && !fin) begin
        if (i >= exp_n) begin
          check(1'b0, "R3 extra byte", out_data, 0);
        end else begin
          req = (exp_k[i] == 0) ? "R2 marker" : (exp_k[i] == 1) ? "R3 payload" : "R4 trailer";
          if (poke) req = {"R9 ", req};
          check(out_data == exp_b[i], {tag, " ", req}, out_data, exp_b[i]);
        end
        if (in_ready && in_valid) din++;
        i++;
        if (i == exp_n) pend = 1;
      end
      cyc++;
    end
    if (!fin) check(1'b0, {tag, " R8 transfer never finished"}, i, exp_n);
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !in_ready && !busy && !done && !size_err, "R1 reset idle",
          {out_valid, in_ready, busy, done, size_err}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && !busy, "R1 idle after release", {out_valid, busy}, 0);

    // R7 zero size
    @(negedge clk);
    xfer_size = '0; start = 1'b1; out_ready = 1'b1;
    @(negedge clk); start = 1'b0; #1;
    check(size_err == 1'b1, "R7 size_err pulse", size_err, 1);
    check(!out_valid && !busy, "R7 no output", {out_valid, busy}, 0);
    @(negedge clk); #1;
    check(size_err == 1'b0, "R7 single cycle", size_err, 0);
    check(!out_valid && !busy && !done, "R7 stays idle", {out_valid, busy, done}, 0);
    out_ready = 1'b0;

    for (int sz = 1; sz <= 20; sz++)
      for (int code = 0; code < 8; code++)
        for (int crc = 0; crc < 2; crc++)
          for (int st = 0; st < 2; st++)
            run(sz, code, crc[0], st, 1'b0, (sz == 1) ? "R6" : "R5");

    for (int code = 0; code < 8; code++) run(300, code, 1'b1, 1, 1'b0, "R5");
    run(300, 6, 1'b0, 0, 1'b0, "R5");
    run(30, 0, 1'b1, 1, 1'b1, "R9");
    run(13, 1, 1'b0, 0, 1'b1, "R9");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule